// File: doc/BRIEF.md
# Configurable Registered Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a small programmable logic array. An external AND-OR plane supplies two sum terms and a handful of product terms; the cell turns them into a tri-state pin and two feedback signals. Static configuration inputs choose, for each of the two registers, whether it acts as a D or a T flip-flop and whether it is clocked by the shared clock pin or by its own clock product term. Further configuration selects whether the pin shows the register or the raw sum, and whether the two sum terms are merged onto the output path or kept apart.

Each register has its own asynchronous clear term. A preset term shared across the array forces registers to 1 at their next edge, and a test preload path writes arbitrary values into both registers. Both register values are always fed back to the array, so either register can be buried while the pin is used as an input.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_ff_t[i]`=0 (D mode), register i takes its routed sum input at each active edge of its selected clock.
- R2: With `cfg_ff_t[i]`=1 (T mode), register i inverts at an active edge when its routed sum input is 1 and keeps its value when it is 0.
- R3: While `ar_pt[i]` is 1, register i is 0 at once, with no clock edge needed; while `rst_n` is 0 both registers are 0.
- R4: With `pl_en`=1 at an active edge, register i loads `pl_data[i]`, taking precedence over the preset term and the D/T update.
- R5: With `sp_pt`=1 and `pl_en`=0 at an active edge, the register becomes 1 whatever its sum input; the clear term of R3 overrides the preset.
- R6: `cfg_clk_pt[i]`=0 clocks register i from the rising edge of `clk_pin`; `cfg_clk_pt[i]`=1 clocks it from the rising edge of `clk_pt[i]`, and edges of `clk_pin` then leave it unchanged.
- R7: With `cfg_combine`=1, register 0 and the output path receive `sum_a | sum_b`; with `cfg_combine`=0 they receive `sum_a` alone. Register 1 always receives `sum_b`.
- R8: With `cfg_reg_out`=1 the pin value `pad_out` equals register 0; with `cfg_reg_out`=0 it equals the routed output-path sum at once.
- R9: `pad_oe` follows `oe_pt`; when `oe_pt` is 0 the pin feedback `pin_fb` equals `pin_in`, otherwise it equals `pad_out`.
- R10: `fb_q[i]` always shows register i, independently of `cfg_reg_out` and `oe_pt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Shared dedicated clock pin |
| rst_n | input | 1 | Power-on reset, active low, clears both registers |
| cfg_ff_t | input | 2 | Per register: 1 = T flip-flop, 0 = D flip-flop |
| cfg_clk_pt | input | 2 | Per register: 1 = clock from product term, 0 = clock pin |
| cfg_reg_out | input | 1 | 1 = registered pin, 0 = combinational pin |
| cfg_combine | input | 1 | 1 = OR both sums onto output path, 0 = keep separate |
| sum_a | input | 1 | First sum term from the array |
| sum_b | input | 1 | Second sum term from the array |
| clk_pt | input | 2 | Per-register clock product terms |
| ar_pt | input | 2 | Per-register asynchronous clear product terms |
| sp_pt | input | 1 | Shared synchronous preset term |
| oe_pt | input | 1 | Output enable product term |
| pl_en | input | 1 | Test preload enable |
| pl_data | input | 2 | Test preload values, bit i for register i |
| pin_in | input | 1 | Value present on the pin when not driven |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin driver enable |
| pin_fb | output | 1 | Pin value fed back to the array |
| fb_q | output | 2 | Register values fed back to the array |

## Verification
The priority controls can meet in one edge: preload together with the shared preset, and the preset together with an asynchronous clear on one register but not the other. The bench raises these terms in the same cycle and checks that register 0 holds the preload value, or is cleared, while register 1 shows the winner of its own priority chain. It also issues a product-term clock pulse inside a clock-pin period so that one register moves while the other is held, and compares every output with its reference model at each falling edge.

// File: rtl/pld_mc_pkg.sv
// Shared constants and encodings for the logic-array output cell.
package pld_mc_pkg;
    localparam int NREG = 2;          // registers per cell
    typedef enum logic {FF_D = 1'b0, FF_T = 1'b1} ff_kind_e;
    typedef enum logic {CK_PIN = 1'b0, CK_PT = 1'b1} ck_src_e;
endpackage

// File: rtl/mc_sum_route.sv
// Routes the two array sums to the registers and the output path.
// Assumes: static cfg_combine; register 0 feeds the pin, register 1 is buried.
module mc_sum_route
    import pld_mc_pkg::*;
(
    input  logic            cfg_combine,
    input  logic            sum_a,
    input  logic            sum_b,
    output logic [NREG-1:0] reg_in,
    output logic            path_sum
);
    // Merge or separate the sums according to configuration.
    always_comb begin
        reg_in    = '0;
        reg_in[0] = cfg_combine ? (sum_a | sum_b) : sum_a;
        reg_in[1] = sum_b;
        path_sum  = reg_in[0];
    end
endmodule

// File: rtl/mc_flop.sv
// One configurable storage element: D or T behaviour, clock from pin or
// product term, async clear, preload, shared preset.
// Assumes: cfg inputs static; clk_pt is glitch-free when selected.
// rst_n acts asynchronously because a product-term clock may never run.
module mc_flop
    import pld_mc_pkg::*;
(
    input  logic clk_pin,
    input  logic clk_pt,
    input  logic rst_n,
    input  logic cfg_t,
    input  logic cfg_ck,
    input  logic d_in,
    input  logic ar,
    input  logic sp,
    input  logic pl_en,
    input  logic pl_d,
    output logic q
);
    logic clk_eff;
    logic clr;

    // Select the clock source and merge clear sources.
    assign clk_eff = (ck_src_e'(cfg_ck) == CK_PT) ? clk_pt : clk_pin;
    assign clr     = ar | ~rst_n;

    // Priority: clear, preload, preset, D/T update.
    always_ff @(posedge clk_eff or posedge clr) begin
        if (clr)                           q <= 1'b0;
        else if (pl_en)                    q <= pl_d;
        else if (sp)                       q <= 1'b1;
        else if (ff_kind_e'(cfg_t) == FF_T) q <= q ^ d_in;
        else                               q <= d_in;
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk_pin) disable iff (!rst_n)
        ar |-> (q == 1'b0));                                         // R3
    AST_PRELOAD_LOADS: assert property (@(posedge clk_eff) disable iff (clr)
        pl_en |=> (q == $past(pl_d)));                               // R4
    AST_PRESET_SETS: assert property (@(posedge clk_eff) disable iff (clr)
        (sp && !pl_en) |=> q);                                       // R5
    AST_TOGGLE_IDLE: assert property (@(posedge clk_eff) disable iff (clr)
        (cfg_t && !sp && !pl_en && !d_in) |=> $stable(q));           // R2
endmodule

// File: rtl/mc_out_path.sv
// Pin-side logic: registered or combinational value, tri-state enable,
// and the pin feedback that reads the pin when the driver is off.
module mc_out_path (
    input  logic cfg_reg_out,
    input  logic path_sum,
    input  logic q0,
    input  logic oe_pt,
    input  logic pin_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pin_fb
);
    // Choose pin value and feedback source.
    always_comb begin
        pad_out = cfg_reg_out ? q0 : path_sum;
        pad_oe  = oe_pt;
        pin_fb  = oe_pt ? pad_out : pin_in;
    end
endmodule

// File: rtl/pld_macrocell.sv
// Output cell of a sum-of-products logic array: two configurable registers,
// sum routing, tri-state pin and independent feedback.
// Assumes: all cfg_* inputs are static during operation.
module pld_macrocell
    import pld_mc_pkg::*;
(
    input  logic            clk_pin,
    input  logic            rst_n,
    input  logic [NREG-1:0] cfg_ff_t,
    input  logic [NREG-1:0] cfg_clk_pt,
    input  logic            cfg_reg_out,
    input  logic            cfg_combine,
    input  logic            sum_a,
    input  logic            sum_b,
    input  logic [NREG-1:0] clk_pt,
    input  logic [NREG-1:0] ar_pt,
    input  logic            sp_pt,
    input  logic            oe_pt,
    input  logic            pl_en,
    input  logic [NREG-1:0] pl_data,
    input  logic            pin_in,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            pin_fb,
    output logic [NREG-1:0] fb_q
);
    logic [NREG-1:0] reg_in;
    logic            path_sum;

    mc_sum_route u_route (
        .cfg_combine(cfg_combine), .sum_a(sum_a), .sum_b(sum_b),
        .reg_in(reg_in), .path_sum(path_sum)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        mc_flop u_ff (
            .clk_pin(clk_pin), .clk_pt(clk_pt[i]), .rst_n(rst_n),
            .cfg_t(cfg_ff_t[i]), .cfg_ck(cfg_clk_pt[i]), .d_in(reg_in[i]),
            .ar(ar_pt[i]), .sp(sp_pt), .pl_en(pl_en), .pl_d(pl_data[i]),
            .q(fb_q[i])
        );
    end

    mc_out_path u_out (
        .cfg_reg_out(cfg_reg_out), .path_sum(path_sum), .q0(fb_q[0]),
        .oe_pt(oe_pt), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_fb(pin_fb)
    );

    AST_REG_PIN_MATCH: assert property (@(posedge clk_pin) disable iff (!rst_n)
        cfg_reg_out |-> (pad_out == fb_q[0]));                       // R8
    AST_COMBINE_OR: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (!cfg_reg_out && cfg_combine && (sum_a || sum_b)) |-> pad_out); // R7
endmodule

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
// Bench: behavioural reference updated on every clock event, compared at
// every falling edge of the clock pin.
module sim_pld_macrocell;
    logic clk_pin = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_ff_t = '0, cfg_clk_pt = '0, clk_pt = '0, ar_pt = '0, pl_data = '0;
    logic cfg_reg_out = 1'b1, cfg_combine = 1'b0, sum_a = 1'b0, sum_b = 1'b0;
    logic sp_pt = 1'b0, oe_pt = 1'b0, pl_en = 1'b0, pin_in = 1'b0;
    logic pad_out, pad_oe, pin_fb;
    logic [1:0] fb_q;

    int n_chk = 0, n_bad = 0;
    string tag = "R3";
    bit mq [2];

    pld_macrocell u0 (.*);

    always #10 clk_pin = ~clk_pin;

    function automatic bit din_of(int i);
        if (i == 0) return cfg_combine ? (sum_a | sum_b) : sum_a;
        return sum_b;
    endfunction

    function automatic void step(int i);
        if (ar_pt[i] || !rst_n) mq[i] = 0;
        else if (pl_en)         mq[i] = pl_data[i];
        else if (sp_pt)         mq[i] = 1;
        else if (cfg_ff_t[i])   mq[i] = mq[i] ^ din_of(i);
        else                    mq[i] = din_of(i);
    endfunction

    function automatic void async_clear();
        for (int i = 0; i < 2; i++) if (ar_pt[i] || !rst_n) mq[i] = 0;
    endfunction

    // Reference update on clock-pin edges for pin-clocked registers.
    always @(posedge clk_pin)
        for (int i = 0; i < 2; i++) if (!cfg_clk_pt[i] || ar_pt[i] || !rst_n) step(i);

    task automatic chk(string what, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        bit po;
        po = cfg_reg_out ? mq[0] : din_of(0);
        chk("fb_q", fb_q, {mq[1], mq[0]});
        chk("pad_out", {1'b0, pad_out}, {1'b0, po});
        chk("pad_oe", {1'b0, pad_oe}, {1'b0, oe_pt});
        chk("pin_fb", {1'b0, pin_fb}, {1'b0, oe_pt ? po : pin_in});
    endtask

    // Wait to falling edge, compare, then apply new sums.
    task automatic cyc(bit a, bit b);
        @(negedge clk_pin);
        check_all();
        sum_a = a; sum_b = b;
        async_clear();
    endtask

    task automatic pt_pulse(int i);
        #3 clk_pt[i] = 1'b1; step(i);
        #3 clk_pt[i] = 1'b0;
    endtask

    initial begin
        // Power-on state, R3
        repeat (2) @(negedge clk_pin);
        check_all();
        rst_n = 1'b1; oe_pt = 1'b1;

        tag = "R1";  // D mode, separate, registered
        for (int k = 0; k < 10; k++) cyc(k[0], k[1] ^ k[2]);

        tag = "R2";  // T mode
        cfg_ff_t = 2'b11;
        for (int k = 0; k < 10; k++) cyc(k[1], k[0]);
        cyc(0, 0); cyc(0, 0);

        tag = "R7";  // combined sums, combinational pin
        cfg_ff_t = 2'b00; cfg_combine = 1'b1;
        for (int k = 0; k < 4; k++) cyc(k[0], k[1]);
        cfg_reg_out = 1'b0;
        for (int k = 0; k < 4; k++) cyc(k[1], k[0]);

        tag = "R8";  // combinational vs registered pin, separate sums
        cfg_combine = 1'b0;
        cyc(1, 0); cyc(0, 1); cyc(1, 1);
        cfg_reg_out = 1'b1;
        cyc(0, 0); cyc(1, 0);

        tag = "R9";  // pin released and read back
        oe_pt = 1'b0;
        for (int k = 0; k < 4; k++) begin cyc(k[0], 1); pin_in = k[1]; end
        oe_pt = 1'b1; cyc(0, 1);

        tag = "R10"; // buried registers with pin released
        oe_pt = 1'b0; pin_in = 1'b1; cfg_reg_out = 1'b0;
        for (int k = 0; k < 4; k++) cyc(k[1], ~k[0]);
        cfg_reg_out = 1'b1; oe_pt = 1'b1;

        tag = "R3";  // async clear without an edge
        cyc(1, 1); cyc(1, 1);
        ar_pt = 2'b01; async_clear();
        #2 chk("immediate clear", fb_q, {mq[1], 1'b0});
        cyc(1, 1);
        ar_pt = 2'b00; cyc(1, 1);

        tag = "R4";  // preload beats preset
        pl_en = 1'b1; pl_data = 2'b01; sp_pt = 1'b1;
        cyc(0, 1);
        pl_data = 2'b10; cyc(1, 0);
        pl_en = 1'b0; sp_pt = 1'b0;
        cyc(0, 0);

        tag = "R5";  // preset beats data, clear beats preset
        sp_pt = 1'b1; cyc(0, 0);
        ar_pt = 2'b01; async_clear(); cyc(0, 0);
        ar_pt = 2'b00; sp_pt = 1'b0; cyc(0, 0); cyc(1, 1);

        tag = "R6";  // register 1 on its product-term clock
        cfg_clk_pt = 2'b10;
        cyc(0, 1); cyc(1, 0); cyc(0, 1);
        pt_pulse(1);
        cyc(1, 0); cyc(1, 0);
        pt_pulse(1);
        cyc(0, 1); cyc(0, 1);

        @(negedge clk_pin); check_all();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule